// File: doc/BRIEF.md
# ADC Autoconversion Slot Sequencer

This block runs autoconversion sessions for an analog-to-digital converter. A session walks through numbered conversion slots one at a time. For each slot it asks a shared converter for one conversion on the channel that a small slot-to-channel table gives, and it stores the returned sample in a result buffer entry whose index equals the slot. A single register holds the session lengths. A session of a programmed value N performs N+1 conversions.

There are two layouts, chosen by the `cascade` input. With `cascade` high, one sequencer owns all sixteen slots and runs from slot 0 upward. With `cascade` low, two sequencers share the converter. Sequencer A covers slots 0 to 7, and if its count exceeds 7 it wraps back to slot 0 and keeps going. Sequencer B covers slots 8 to 15. A simple word-wide port gives read and write access to the length register, a status word, the channel table and the result buffer.

Top module: `adc_slot_sequencer`

## Requirements
- R1: Register address 0 is 16 bits wide. Bits 6:0 are writable and read back as written. Bits 15:7 always read zero, and writing them has no effect.
- R2: Register address 0 bits 3:0 hold the length field of sequencer A (value N gives N+1 conversions, from 1 to 16). Bits 6:4 hold the length field of sequencer B (value M gives M+1 conversions, from 1 to 8).
- R3: With `cascade` = 1, a pulse on `trig_a` runs N+1 conversions on slots 0, 1, ..., N in that order. `trig_b` is ignored in this mode: no conversion is issued, and status bit 9 stays 0.
- R4: With `cascade` = 0, a pulse on `trig_b` runs M+1 conversions on slots 8, 9, ..., 8+M in that order.
- R5: With `cascade` = 0 and an A length field of 8 or more, A's conversion k (counting from 0) uses slot k mod 8. A later conversion overwrites the result of an earlier one on the same slot.
- R6: Each returned sample is stored in result entry number = current slot. Entry s reads at address 32+s, zero-extended to 16 bits.
- R7: Channel table entry s is read and written at address 16+s. The conversion request for slot s presents `conv_ch` = entry s. After reset, entry s holds s.
- R8: A trigger that arrives while its own sequencer is active is ignored. The session keeps its length and its slot progression.
- R9: The cycle after the final conversion of a session completes, that sequencer's end pulse (`eos_a` or `eos_b`) is high for exactly one cycle. In that same cycle the sequencer is idle and its counter is back at 0.
- R10: When both sequencers wait for the free converter in the same cycle, A is served first. A conversion already issued to B is never preempted; it completes, and then A is served.
- R11: Address 1 is a read-only status word: bits 3:0 give A's counter, bits 6:4 give B's counter, bit 8 gives A active, and bit 9 gives B active. All other bits read 0.
- R12: A synchronous active-high reset stops any session and puts everything in its initial state: sequencers idle with counters at 0, length register 0, channel table at identity, results 0.
- R13: `conv_req` is a one-cycle pulse, and at most one conversion is outstanding at a time. The next request comes no earlier than the cycle after `conv_done`. A `conv_done` that arrives when no conversion is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational from `reg_addr`) |
| cascade | input | 1 | 1 = one 16-slot sequencer, 0 = two 8-slot sequencers |
| trig_a | input | 1 | Start trigger for sequencer A |
| trig_b | input | 1 | Start trigger for sequencer B (dual layout only) |
| conv_req | output | 1 | One-cycle conversion start request |
| conv_ch | output | 4 | Channel for the requested conversion |
| conv_done | input | 1 | Converter completion strobe |
| conv_data | input | 12 | Converted sample, valid with `conv_done` |
| eos_a | output | 1 | End-of-session pulse, sequencer A |
| eos_b | output | 1 | End-of-session pulse, sequencer B |

## Verification
The case of interest is when both sequencers are waiting for the shared converter in the same cycle. The bench provokes it in two ways. First, it pulses both triggers in one cycle. Second, it starts B and then triggers A in the very cycle B's first request goes out. The converter model logs the channel of every request, and the bench compares that order with the order the priority rule gives: A's slots come first in the first case, and B's first slot, then all of A, then the rest of B in the second case. A second coincidence is a trigger landing on an active session. Here the bench checks the conversion count, the end-pulse count and the counter peak read from the status word.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int REG_W    = 16;
    localparam int ADDR_W   = 6;
    localparam int SLOT_W   = 4;
    localparam int NSLOT    = 1 << SLOT_W;
    localparam int A_CNT_W  = SLOT_W;
    localparam int B_CNT_W  = SLOT_W - 1;
    localparam int LIM_W    = A_CNT_W + B_CNT_W;

    localparam logic [ADDR_W-1:0] ADR_LIMIT  = 6'd0;
    localparam logic [ADDR_W-1:0] ADR_STATUS = 6'd1;
    localparam logic [1:0]        PAGE_CTRL  = 2'b00;
    localparam logic [1:0]        PAGE_TBL   = 2'b01;
    localparam logic [1:0]        PAGE_RES   = 2'b10;

    typedef enum logic {
        OWNER_A = 1'b0,
        OWNER_B = 1'b1
    } owner_e;

    // Length register layout: B field above A field.
    typedef struct packed {
        logic [B_CNT_W-1:0] lim_b;
        logic [A_CNT_W-1:0] lim_a;
    } limit_t;

    typedef struct packed {
        logic active;
        logic inflight;
        logic eos;
    } seq_flags_t;

    // Sequencer A slot: full count when cascaded, low bits (wrapping) when dual.
    function automatic logic [SLOT_W-1:0] slot_of_a(input logic [A_CNT_W-1:0] cnt,
                                                    input logic casc);
        return casc ? cnt : {1'b0, cnt[B_CNT_W-1:0]};
    endfunction

    // Sequencer B slot: upper half of the slot space.
    function automatic logic [SLOT_W-1:0] slot_of_b(input logic [B_CNT_W-1:0] cnt);
        return {1'b1, cnt};
    endfunction

endpackage

// File: rtl/adc_seq_unit.sv
module adc_seq_unit
    import adc_seq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             trig,
    input  logic [CNT_W-1:0] limit,
    input  logic             grant,
    input  logic             done,
    output logic             active,
    output logic             pending,
    output logic             eos,
    output logic [CNT_W-1:0] cnt
);

    seq_flags_t       st_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            cnt_q <= '0;
        end else begin
            st_q.eos <= 1'b0;
            if (!st_q.active) begin
                cnt_q <= '0;
                if (trig && enable) begin
                    st_q.active <= 1'b1;
                end
            end else begin
                if (grant) begin
                    st_q.inflight <= 1'b1;
                end
                if (done) begin
                    st_q.inflight <= 1'b0;
                    if (cnt_q == limit) begin
                        st_q.active <= 1'b0;
                        st_q.eos    <= 1'b1;
                        cnt_q       <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end
        end
    end

    assign active  = st_q.active;
    assign pending = st_q.active && !st_q.inflight;
    assign eos     = st_q.eos;
    assign cnt     = cnt_q;

endmodule

// File: rtl/adc_conv_arbiter.sv
module adc_conv_arbiter
    import adc_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pend_a,
    input  logic   pend_b,
    input  logic   conv_done,
    output logic   grant_a,
    output logic   grant_b,
    output logic   conv_req,
    output logic   done_a,
    output logic   done_b,
    output owner_e owner
);

    logic   busy_q;
    owner_e owner_q;
    logic   finish;

    assign grant_a  = !busy_q && pend_a;
    assign grant_b  = !busy_q && pend_b && !pend_a;
    assign conv_req = grant_a || grant_b;
    assign finish   = busy_q && conv_done;
    assign done_a   = finish && (owner_q == OWNER_A);
    assign done_b   = finish && (owner_q == OWNER_B);
    assign owner    = owner_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            owner_q <= OWNER_A;
        end else if (conv_req) begin
            busy_q  <= 1'b1;
            owner_q <= grant_a ? OWNER_A : OWNER_B;
        end else if (finish) begin
            busy_q <= 1'b0;
        end
    end

endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int CH_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic [REG_W-1:0]  status,
    output limit_t            limits,
    input  logic [SLOT_W-1:0] lk_slot,
    output logic [CH_W-1:0]   lk_ch,
    input  logic              res_we,
    input  logic [SLOT_W-1:0] res_slot,
    input  logic [DATA_W-1:0] res_data
);

    limit_t            lim_q;
    logic [CH_W-1:0]   tbl_q [NSLOT];
    logic [DATA_W-1:0] res_q [NSLOT];
    logic [1:0]        page;
    logic [SLOT_W-1:0] idx;
    logic              unused_wbits;

    assign page         = addr[ADDR_W-1:SLOT_W];
    assign idx          = addr[SLOT_W-1:0];
    assign unused_wbits = ^wdata[REG_W-1:LIM_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            lim_q <= '0;
        end else if (we && addr == ADR_LIMIT) begin
            lim_q <= wdata[LIM_W-1:0];
        end
    end

    generate
        for (genvar s = 0; s < NSLOT; s++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    tbl_q[s] <= CH_W'(s);
                end else if (we && page == PAGE_TBL && idx == SLOT_W'(s)) begin
                    tbl_q[s] <= wdata[CH_W-1:0];
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    res_q[s] <= '0;
                end else if (res_we && res_slot == SLOT_W'(s)) begin
                    res_q[s] <= res_data;
                end
            end
        end
    endgenerate

    always_comb begin
        rdata = '0;
        unique case (page)
            PAGE_CTRL: begin
                if (addr == ADR_LIMIT) begin
                    rdata = {{(REG_W-LIM_W){1'b0}}, lim_q};
                end else if (addr == ADR_STATUS) begin
                    rdata = status;
                end
            end
            PAGE_TBL: rdata = {{(REG_W-CH_W){1'b0}}, tbl_q[idx]};
            PAGE_RES: rdata = {{(REG_W-DATA_W){1'b0}}, res_q[idx]};
            default:  rdata = '0;
        endcase
    end

    assign limits = lim_q;
    assign lk_ch  = tbl_q[lk_slot];

endmodule

// File: rtl/adc_slot_sequencer.sv
module adc_slot_sequencer
    import adc_seq_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int CH_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              cascade,
    input  logic              trig_a,
    input  logic              trig_b,
    output logic              conv_req,
    output logic [CH_W-1:0]   conv_ch,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic              eos_a,
    output logic              eos_b
);

    limit_t              limits;
    logic                act_a, act_b, pend_a, pend_b;
    logic [A_CNT_W-1:0]  cnt_a;
    logic [B_CNT_W-1:0]  cnt_b;
    logic                grant_a, grant_b, done_a, done_b;
    owner_e              owner;
    logic [SLOT_W-1:0]   slot_a, slot_b, wr_slot, req_slot;
    logic [REG_W-1:0]    status;

    adc_seq_unit #(.CNT_W(A_CNT_W)) u_seq_a (
        .clk(clk), .rst(rst), .enable(1'b1), .trig(trig_a),
        .limit(limits.lim_a), .grant(grant_a), .done(done_a),
        .active(act_a), .pending(pend_a), .eos(eos_a), .cnt(cnt_a)
    );

    adc_seq_unit #(.CNT_W(B_CNT_W)) u_seq_b (
        .clk(clk), .rst(rst), .enable(!cascade), .trig(trig_b),
        .limit(limits.lim_b), .grant(grant_b), .done(done_b),
        .active(act_b), .pending(pend_b), .eos(eos_b), .cnt(cnt_b)
    );

    adc_conv_arbiter u_arb (
        .clk(clk), .rst(rst), .pend_a(pend_a), .pend_b(pend_b),
        .conv_done(conv_done), .grant_a(grant_a), .grant_b(grant_b),
        .conv_req(conv_req), .done_a(done_a), .done_b(done_b), .owner(owner)
    );

    assign slot_a   = slot_of_a(cnt_a, cascade);
    assign slot_b   = slot_of_b(cnt_b);
    assign req_slot = grant_a ? slot_a : slot_b;
    assign wr_slot  = (owner == OWNER_A) ? slot_a : slot_b;

    assign status = {{(REG_W-10){1'b0}}, act_b, act_a, 1'b0, cnt_b, cnt_a};

    adc_seq_regs #(.DATA_W(DATA_W), .CH_W(CH_W)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .status(status),
        .limits(limits), .lk_slot(req_slot), .lk_ch(conv_ch),
        .res_we(done_a || done_b), .res_slot(wr_slot), .res_data(conv_data)
    );

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker
    import adc_seq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              cascade,
    input logic              trig_a,
    input logic              trig_b,
    input logic              conv_req,
    input logic              eos_a,
    input logic              eos_b,
    input logic              pend_a,
    input logic              pend_b,
    input logic              grant_a,
    input logic              act_a,
    input logic              act_b,
    input logic [A_CNT_W-1:0] cnt_a,
    input logic              done_a
);

    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADR_LIMIT) |-> (reg_rdata[REG_W-1:LIM_W] == '0));

    assert_b_off_cascade_R3: assert property (@(posedge clk) disable iff (rst)
        (cascade && !act_b && trig_b) |=> !act_b);

    assert_trig_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (act_a && trig_a && !done_a) |=> (act_a && cnt_a == $past(cnt_a)));

    assert_eos_pulse_a_R9: assert property (@(posedge clk) disable iff (rst)
        eos_a |=> !eos_a);

    assert_eos_pulse_b_R9: assert property (@(posedge clk) disable iff (rst)
        eos_b |=> !eos_b);

    assert_eos_idle_R9: assert property (@(posedge clk) disable iff (rst)
        eos_a |-> (!act_a && cnt_a == '0));

    assert_a_first_R10: assert property (@(posedge clk) disable iff (rst)
        (conv_req && pend_a && pend_b) |-> grant_a);

    assert_single_req_R13: assert property (@(posedge clk) disable iff (rst)
        conv_req |=> !conv_req);

endmodule

bind adc_slot_sequencer adc_seq_checker u_chk (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .cascade(cascade), .trig_a(trig_a), .trig_b(trig_b),
    .conv_req(conv_req), .eos_a(eos_a), .eos_b(eos_b),
    .pend_a(pend_a), .pend_b(pend_b), .grant_a(grant_a),
    .act_a(act_a), .act_b(act_b), .cnt_a(cnt_a), .done_a(done_a)
);

// File: tb/sim_adc_slot_sequencer.sv
`timescale 1ns/1ps
module sim_adc_slot_sequencer;

    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        cascade = 1'b1;
    logic        trig_a = 1'b0, trig_b = 1'b0;
    logic        conv_req;
    logic [3:0]  conv_ch;
    logic        conv_done = 1'b0;
    logic [11:0] conv_data = '0;
    logic        eos_a, eos_b;

    int n_chk = 0, n_bad = 0;
    int nconv = 0, n_eos_a = 0, n_eos_b = 0, n_spacing = 0;
    int log_ch [0:1023];
    bit poke = 1'b0;
    bit ended = 1'b0;

    always #5 clk = ~clk;

    adc_slot_sequencer u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cascade(cascade),
        .trig_a(trig_a), .trig_b(trig_b), .conv_req(conv_req),
        .conv_ch(conv_ch), .conv_done(conv_done), .conv_data(conv_data),
        .eos_a(eos_a), .eos_b(eos_b)
    );

    function automatic logic [11:0] dval(input int i);
        return 12'((i * 421 + 77) % 4096);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        end
    endtask

    // Converter model: latency LAT, sample derived from global index.
    initial begin
        forever begin
            @(negedge clk);
            conv_done = 1'b0;
            if (poke) begin
                poke      = 1'b0;
                conv_done = 1'b1;
                conv_data = 12'hABC;
            end else if (conv_req) begin
                int idx;
                idx = nconv;
                log_ch[idx % 1024] = int'(conv_ch);
                nconv++;
                repeat (LAT) @(negedge clk);
                conv_done = 1'b1;
                conv_data = dval(idx);
            end
        end
    end

    // Monitor: end pulses and back-to-back requests (R13).
    initial begin
        logic prev_req;
        prev_req = 1'b0;
        forever begin
            @(negedge clk);
            if (eos_a) n_eos_a++;
            if (eos_b) n_eos_b++;
            if (conv_req && prev_req) n_spacing++;
            prev_req = conv_req;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = 6'(a);
        reg_wdata = 16'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        reg_addr = 6'(a);
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic pulse(input bit a, input bit b);
        @(negedge clk);
        trig_a = a;
        trig_b = b;
        @(negedge clk);
        trig_a = 1'b0;
        trig_b = 1'b0;
    endtask

    // Wait for end pulses while sampling the status word each cycle.
    task automatic wait_end(input int ea, input int eb, output int ma, output int mb);
        bit ok;
        ok = 1'b0;
        ma = 0;
        mb = 0;
        reg_addr = 6'd1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            #1;
            if (int'(reg_rdata[3:0]) > ma) ma = int'(reg_rdata[3:0]);
            if (int'(reg_rdata[6:4]) > mb) mb = int'(reg_rdata[6:4]);
            if (n_eos_a >= ea && n_eos_b >= eb) begin
                ok = 1'b1;
                break;
            end
        end
        chk("R9 session ended", int'(ok), 1);
        repeat (4) @(negedge clk);
        chk("R9 eos_a pulse count", n_eos_a, ea);
        chk("R9 eos_b pulse count", n_eos_b, eb);
    endtask

    task automatic session(input int lim, input bit casc, input bit ta, input bit tb,
                           output int g0, output int ma, output int mb);
        int ea, eb;
        cascade = casc;
        wr(0, lim);
        g0 = nconv;
        ea = n_eos_a + int'(ta);
        eb = n_eos_b + int'(tb);
        pulse(ta, tb);
        wait_end(ea, eb, ma, mb);
    endtask

    initial begin
        int d, g0, ma, mb;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Reset state (R12, R7, R11)
        rd(0, d);  chk("R12 limit reg reset", d, 0);
        rd(1, d);  chk("R11 status reset", d, 0);
        rd(16 + 5, d); chk("R7 table reset identity", d, 5);
        rd(32 + 3, d); chk("R12 result reset", d, 0);
        chk("R13 no request at reset", int'(conv_req), 0);

        // Reserved bits (R1)
        wr(0, 16'hFFFF); rd(0, d); chk("R1 readback all ones", d, 16'h007F);
        wr(0, 16'hFF80); rd(0, d); chk("R1 reserved write ignored", d, 0);

        // Cascaded sweep over all lengths (R2, R3, R6)
        for (int n = 0; n < 16; n++) begin
            session(n, 1'b1, 1'b1, 1'b0, g0, ma, mb);
            chk($sformatf("R3 cascade n=%0d conversion count", n), nconv - g0, n + 1);
            chk($sformatf("R11 cascade n=%0d counter peak", n), ma, n);
            for (int k = 0; k <= n; k++) begin
                chk($sformatf("R3 cascade n=%0d slot order", n), log_ch[g0 + k], k);
                rd(32 + k, d);
                chk($sformatf("R6 cascade n=%0d result slot %0d", n, k), d, int'(dval(g0 + k)));
            end
            rd(1, d);
            chk("R9 status idle after end", d, 0);
        end

        // trig_b ignored when cascaded (R3)
        g0 = nconv;
        pulse(1'b0, 1'b1);
        reg_addr = 6'd1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            #1;
            if (reg_rdata[9]) begin
                chk("R3 cascade B stays idle", 1, 0);
            end
        end
        chk("R3 cascade trig_b no conversions", nconv - g0, 0);

        // Dual mode sequencer B sweep (R2, R4, R6)
        for (int m = 0; m < 8; m++) begin
            session(m << 4, 1'b0, 1'b0, 1'b1, g0, ma, mb);
            chk($sformatf("R4 B m=%0d conversion count", m), nconv - g0, m + 1);
            chk($sformatf("R11 B m=%0d counter peak", m), mb, m);
            for (int k = 0; k <= m; k++) begin
                chk($sformatf("R4 B m=%0d slot order", m), log_ch[g0 + k], 8 + k);
                rd(32 + 8 + k, d);
                chk($sformatf("R6 B m=%0d result slot %0d", m, 8 + k), d, int'(dval(g0 + k)));
            end
        end

        // Dual mode A wrap past slot 7 (R5)
        for (int n = 8; n < 16; n++) begin
            session(n, 1'b0, 1'b1, 1'b0, g0, ma, mb);
            chk($sformatf("R5 wrap n=%0d conversion count", n), nconv - g0, n + 1);
            chk($sformatf("R5 wrap n=%0d counter peak", n), ma, n);
            for (int k = 0; k <= n; k++) begin
                chk($sformatf("R5 wrap n=%0d slot of conv %0d", n, k), log_ch[g0 + k], k % 8);
            end
            for (int s = 0; s < 8; s++) begin
                int kk;
                kk = (s + 8 <= n) ? s + 8 : s;
                rd(32 + s, d);
                chk($sformatf("R5 wrap n=%0d result slot %0d", n, s), d, int'(dval(g0 + kk)));
            end
        end

        // Priority: both triggers in one cycle (R10)
        session(16'h0023, 1'b0, 1'b1, 1'b1, g0, ma, mb);
        chk("R10 joint start count", nconv - g0, 7);
        for (int k = 0; k < 7; k++) begin
            chk($sformatf("R10 joint start order %0d", k), log_ch[g0 + k], (k < 4) ? k : 8 + k - 4);
        end

        // Priority without preemption: A arrives while B's first is in flight (R10)
        begin
            int ea, eb;
            cascade = 1'b0;
            wr(0, 16'h0023);
            g0 = nconv;
            ea = n_eos_a + 1;
            eb = n_eos_b + 1;
            pulse(1'b0, 1'b1);
            chk("R10 B request visible", int'(conv_req), 1);
            trig_a = 1'b1;
            @(negedge clk);
            trig_a = 1'b0;
            wait_end(ea, eb, ma, mb);
            chk("R10 late A count", nconv - g0, 7);
            chk("R10 late A order 0", log_ch[g0 + 0], 8);
            for (int k = 0; k < 4; k++) begin
                chk($sformatf("R10 late A order %0d", k + 1), log_ch[g0 + 1 + k], k);
            end
            chk("R10 late A order 5", log_ch[g0 + 5], 9);
            chk("R10 late A order 6", log_ch[g0 + 6], 10);
        end

        // Retrigger during an active session (R8)
        begin
            int ea;
            cascade = 1'b1;
            wr(0, 5);
            g0 = nconv;
            ea = n_eos_a + 1;
            pulse(1'b1, 1'b0);
            repeat (6) @(negedge clk);
            pulse(1'b1, 1'b0);
            wait_end(ea, n_eos_b, ma, mb);
            chk("R8 retrigger count", nconv - g0, 6);
            chk("R8 retrigger counter peak", ma, 5);
            for (int k = 0; k < 6; k++) begin
                chk("R8 retrigger slot order", log_ch[g0 + k], k);
            end
        end

        // Channel table remap (R7)
        for (int k = 0; k < 4; k++) wr(16 + k, 15 - k);
        rd(16 + 2, d); chk("R7 table readback", d, 13);
        session(3, 1'b1, 1'b1, 1'b0, g0, ma, mb);
        for (int k = 0; k < 4; k++) begin
            chk($sformatf("R7 remapped channel slot %0d", k), log_ch[g0 + k], 15 - k);
            rd(32 + k, d);
            chk("R6 remap result by slot", d, int'(dval(g0 + k)));
        end

        // Stray completion strobe while idle (R13)
        rd(32 + 0, d);
        g0 = d;
        @(negedge clk);
        poke = 1'b1;
        repeat (4) @(negedge clk);
        rd(32 + 0, d); chk("R13 stray done leaves results", d, g0);
        rd(1, d);      chk("R13 stray done leaves status", d, 0);
        chk("R13 no back-to-back requests", n_spacing, 0);

        // Reset in mid-session (R12)
        cascade = 1'b1;
        wr(0, 15);
        pulse(1'b1, 1'b0);
        repeat (6) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        g0 = nconv;
        rd(1, d);      chk("R12 status after reset", d, 0);
        rd(0, d);      chk("R12 limit after reset", d, 0);
        rd(16 + 0, d); chk("R12 table restored", d, 0);
        rd(32 + 1, d); chk("R12 results cleared", d, 0);
        repeat (10) @(negedge clk);
        chk("R12 no requests after reset", nconv - g0, 0);

        summary();
        $finish;
    end

endmodule